// File: doc/BRIEF.md
# Single-Wire Pulse Up/Down Code Controller

This block keeps a 7-bit setting code and moves it one step at a time from pulses seen on a single three-level control wire. The analogue front end has already reduced the wire to two flags: one raised while the wire is driven high, one raised while it is driven low, and neither while it rests at mid-rail. A long low excursion raises the code by one and a long high excursion lowers it by one. A larger code selects more sink current downstream and so a lower output level.

Short glitches are rejected. Consecutive pulses must be separated by a minimum time at mid-rail. An enable input gates the whole interface, and after enable rises a start-up time must pass before the wire is watched. The first pulse that would qualify after the interface becomes ready is thrown away, so that a stray edge from power sequencing cannot move the code. At reset the code is preset from a stored value supplied on a load port, nominally the half-scale value 64. The code saturates at both ends. All time limits are parameters counted in clock cycles, and the flags pass through a two-stage synchroniser before any timing is applied.

Top module: `pulse_code_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, `code_o` takes the value on `load_code_i` at that edge and holds it until a qualified step arrives.
- R2: A low excursion (`ctl_lo_i`=1, `ctl_hi_i`=0) lasting at least T_ACCEPT cycles, followed by a return to mid-rail, raises `code_o` by exactly one.
- R3: A high excursion (`ctl_hi_i`=1, `ctl_lo_i`=0) lasting at least T_ACCEPT cycles, followed by a return to mid-rail, lowers `code_o` by exactly one.
- R4: Any excursion shorter than T_ACCEPT cycles leaves `code_o` unchanged. This covers short glitches as well as widths in the band between the glitch limit and the acceptance limit.
- R5: After reset, and again after every period with the enable low, the first excursion that would otherwise qualify is discarded and leaves `code_o` unchanged. Later qualified excursions step the code.
- R6: An excursion steps the code only if the wire was at mid-rail for at least T_GAP consecutive cycles, counted while the interface is ready, immediately before the excursion began.
- R7: While `en_i` is low, the wire has no effect on `code_o`. After `en_i` rises, excursions are not measured until T_STARTUP synchronised cycles of enable have passed.
- R8: `code_o` never goes above 127 or below 0. An increment at 127 or a decrement at 0 is discarded, and the code does not wrap.
- R9: If the wire reverses directly from one driven level to the other without passing through mid-rail, neither excursion steps the code.
- R10: Both flags raised together are treated as mid-rail.
- R11: Both flags and the enable pass through two flip-flop stages. A qualified step shows on `code_o` at the third rising edge after the wire returns to mid-rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all time limits count its cycles |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_i | input | 1 | Interface enable; low makes the wire ignored |
| ctl_hi_i | input | 1 | Wire driven high (asynchronous flag) |
| ctl_lo_i | input | 1 | Wire driven low (asynchronous flag) |
| load_code_i | input | 7 | Stored code loaded during reset |
| code_o | output | 7 | Current setting code |

## Verification
The hardest case to reach from the ports is an excursion that is otherwise perfect but is refused for a reason set up earlier. Examples are the discarded first pulse after enable, a pulse that follows too short a rest at mid-rail, and a pulse that arrives just after a reversal. The stimulus creates each one by chaining exact cycle counts of wire levels after a fresh enable or reset. It also reloads the code at 126 and at 1 through the reset preset so that the saturation limits are reached in a few pulses. A behavioural model running beside the design compares the code on every clock, so each discarded or delayed step is seen in the cycle it would have appeared.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    parameter int unsigned PCC_CODE_W = 7;

    typedef logic [PCC_CODE_W-1:0] code_t;

    // Level of the control wire after decoding the two flags
    typedef enum logic [1:0] {
        LV_MID  = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2
    } wire_lvl_e;

    // Step request from pulse qualifier to code register
    typedef struct packed {
        logic vld;
        logic up;
    } step_req_t;

    function automatic wire_lvl_e decode_lvl(input logic hi, input logic lo);
        if (hi && !lo)      return LV_HIGH;
        else if (lo && !hi) return LV_LOW;
        else                return LV_MID;
    endfunction

    function automatic code_t sat_step(input code_t c, input logic up);
        if (up) return (c == '1) ? c : c + code_t'(1);
        else    return (c == '0) ? c : c - code_t'(1);
    endfunction

endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcc_startup.sv
module pcc_startup #(
    parameter int unsigned T_STARTUP = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_s,
    output logic ready_o
);
    localparam int unsigned CNT_W = $clog2(T_STARTUP + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(T_STARTUP);

    logic [CNT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst || !en_s)          wait_q <= '0;
        else if (wait_q != CNT_MAX) wait_q <= wait_q + CNT_W'(1);
    end

    assign ready_o = en_s && (wait_q == CNT_MAX);
endmodule

// File: rtl/pcc_pulse_qual.sv
module pcc_pulse_qual
    import pcc_pkg::*;
#(
    parameter int unsigned T_ACCEPT = 2000,
    parameter int unsigned T_GAP    = 100
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ready_i,
    input  wire_lvl_e lvl_i,
    output step_req_t step_o
);
    localparam int unsigned WID_W = $clog2(T_ACCEPT + 1);
    localparam int unsigned GAP_W = $clog2(T_GAP + 1);
    localparam logic [WID_W-1:0] WID_MAX = WID_W'(T_ACCEPT);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(T_GAP);

    wire_lvl_e        pol_q;
    logic [WID_W-1:0] width_q;
    logic [GAP_W-1:0] gap_q;
    logic             armed_q;

    // A pulse ends when the wire settles back at mid-rail
    logic pulse_end;
    assign pulse_end = ready_i && (lvl_i == LV_MID) && (pol_q != LV_MID);

    always_comb begin
        step_o.vld = pulse_end && armed_q && (width_q >= WID_MAX);
        step_o.up  = (pol_q == LV_LOW);
    end

    always_ff @(posedge clk) begin
        if (rst || !ready_i) begin
            pol_q   <= LV_MID;
            width_q <= '0;
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else if (lvl_i == LV_MID) begin
            if (gap_q != GAP_MAX) gap_q <= gap_q + GAP_W'(1);
            pol_q   <= LV_MID;
            width_q <= '0;
        end else begin
            gap_q <= '0;
            if (pol_q == LV_MID) begin
                pol_q   <= lvl_i;
                width_q <= WID_W'(1);
                armed_q <= (gap_q == GAP_MAX);
            end else if (pol_q == lvl_i) begin
                if (width_q != WID_MAX) width_q <= width_q + WID_W'(1);
            end else begin
                // direct reversal: restart without credit
                pol_q   <= lvl_i;
                width_q <= WID_W'(1);
                armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcc_code_reg.sv
module pcc_code_reg
    import pcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_s,
    input  code_t     load_i,
    input  step_req_t step_i,
    output code_t     code_o
);
    code_t code_q;
    logic  discard_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q    <= load_i;
            discard_q <= 1'b1;
        end else begin
            if (!en_s) discard_q <= 1'b1;
            if (step_i.vld) begin
                if (discard_q) discard_q <= 1'b0;
                else           code_q    <= sat_step(code_q, step_i.up);
            end
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/pulse_code_ctrl.sv
module pulse_code_ctrl
    import pcc_pkg::*;
#(
    parameter int unsigned T_ACCEPT    = 2000,
    parameter int unsigned T_GAP       = 100,
    parameter int unsigned T_STARTUP   = 10000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_i,
    input  logic                  ctl_hi_i,
    input  logic                  ctl_lo_i,
    input  logic [PCC_CODE_W-1:0] load_code_i,
    output logic [PCC_CODE_W-1:0] code_o
);
    localparam int unsigned N_SYNC = 3;

    logic [N_SYNC-1:0] raw_w, sync_w;
    logic              ready_w;
    wire_lvl_e         lvl_w;
    step_req_t         step_w;

    assign raw_w = {en_i, ctl_hi_i, ctl_lo_i};

    pcc_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_w),
        .q_o (sync_w)
    );

    assign lvl_w = decode_lvl(sync_w[1], sync_w[0]);

    pcc_startup #(.T_STARTUP(T_STARTUP)) i_startup (
        .clk     (clk),
        .rst     (rst),
        .en_s    (sync_w[2]),
        .ready_o (ready_w)
    );

    pcc_pulse_qual #(.T_ACCEPT(T_ACCEPT), .T_GAP(T_GAP)) i_qual (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready_w),
        .lvl_i   (lvl_w),
        .step_o  (step_w)
    );

    pcc_code_reg i_code (
        .clk    (clk),
        .rst    (rst),
        .en_s   (sync_w[2]),
        .load_i (load_code_i),
        .step_i (step_w),
        .code_o (code_o)
    );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker (
    input logic       clk,
    input logic       rst,
    input logic [6:0] code_o,
    input logic [6:0] load_code_i,
    input logic       ready
);
    logic seen_q = 1'b0;
    always_ff @(posedge clk) seen_q <= 1'b1;

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(rst)) |-> (code_o == $past(load_code_i))); // R1

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && (code_o != $past(code_o))) |->
        ((code_o == $past(code_o) + 7'd1) || (code_o == $past(code_o) - 7'd1))); // R2

    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && !$past(ready)) |-> $stable(code_o)); // R7

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && ($past(code_o) == 7'd127)) |-> (code_o != 7'd0)); // R8

    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && ($past(code_o) == 7'd0)) |-> (code_o != 7'd127)); // R8
endmodule

bind pulse_code_ctrl pcc_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .code_o      (code_o),
    .load_code_i (load_code_i),
    .ready       (ready_w)
);

// File: tb/test_pulse_code_ctrl.sv
module test_pulse_code_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TA = 20;
    localparam int TG = 4;
    localparam int TS = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic       ctl_hi_i = 1'b0;
    logic       ctl_lo_i = 1'b0;
    logic [6:0] load_code_i = 7'd64;
    logic [6:0] code_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_code_ctrl #(.T_ACCEPT(TA), .T_GAP(TG), .T_STARTUP(TS)) i_pulse_code_ctrl (
        .clk(clk), .rst(rst), .en_i(en_i), .ctl_hi_i(ctl_hi_i),
        .ctl_lo_i(ctl_lo_i), .load_code_i(load_code_i), .code_o(code_o)
    );

    // Behavioural reference model
    int m_code, m_wait, m_pol, m_width, m_gap;
    bit m_armed, m_first;
    bit sh[$], sl[$], se[$];

    always @(posedge clk) begin
        if (rst) begin
            m_code = load_code_i; m_wait = 0; m_pol = 0; m_width = 0;
            m_gap = 0; m_armed = 0; m_first = 1;
            sh = '{0, 0}; sl = '{0, 0}; se = '{0, 0};
            cmp_on = 1'b1;
        end else begin
            bit h, l, e, rdy, qual;
            int lvl, n_pol, n_width, n_gap;
            bit n_armed;
            h = sh[0]; l = sl[0]; e = se[0];
            rdy = e && (m_wait == TS);
            lvl = (h && !l) ? -1 : ((l && !h) ? 1 : 0);
            qual = 0;
            n_pol = m_pol; n_width = m_width; n_gap = m_gap; n_armed = m_armed;
            if (!rdy) begin
                n_pol = 0; n_width = 0; n_gap = 0; n_armed = 0;
            end else if (lvl == 0) begin
                n_gap = (m_gap < TG) ? m_gap + 1 : TG;
                if (m_pol != 0 && m_armed && m_width >= TA) qual = 1;
                n_pol = 0; n_width = 0;
            end else begin
                n_gap = 0;
                if (m_pol == 0) begin
                    n_pol = lvl; n_width = 1; n_armed = (m_gap == TG);
                end else if (m_pol == lvl) begin
                    n_width = (m_width < TA) ? m_width + 1 : TA;
                end else begin
                    n_pol = lvl; n_width = 1; n_armed = 0;
                end
            end
            if (!e) m_first = 1;
            if (qual) begin
                if (m_first) m_first = 0;
                else if (m_pol > 0 && m_code < 127) m_code++;
                else if (m_pol < 0 && m_code > 0) m_code--;
            end
            m_wait = !e ? 0 : ((m_wait < TS) ? m_wait + 1 : TS);
            m_pol = n_pol; m_width = n_width; m_gap = n_gap; m_armed = n_armed;
            void'(sh.pop_front()); void'(sl.pop_front()); void'(se.pop_front());
            sh.push_back(ctl_hi_i); sl.push_back(ctl_lo_i); se.push_back(en_i);
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            checks++;
            if (code_o !== 7'(m_code)) begin
                errors++;
                $display("FAIL %s model compare: code_o=%0d expected=%0d at %0t",
                         cur_req, code_o, m_code, $time);
            end
        end
    end

    task automatic check_code(input int exp, input string req);
        checks++;
        if (code_o !== 7'(exp)) begin
            errors++;
            $display("FAIL %s: code_o=%0d expected=%0d", req, code_o, exp);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); ctl_hi_i = 0; ctl_lo_i = 0;
        repeat (n) @(negedge clk);
    endtask

    // drive level (+1 low/up, -1 high/down, 2 both) for w cycles then mid for 10
    task automatic pulse(input int dir, input int w);
        @(negedge clk);
        ctl_lo_i = (dir == 1) || (dir == 2);
        ctl_hi_i = (dir == -1) || (dir == 2);
        repeat (w) @(negedge clk);
        ctl_hi_i = 0; ctl_lo_i = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_reset(input int load);
        @(negedge clk); rst = 1; en_i = 0; load_code_i = 7'(load);
        repeat (3) @(negedge clk); rst = 0;
    endtask

    task automatic enable_wait();
        @(negedge clk); en_i = 1;
        repeat (TS + 10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1"; rst = 0;
        @(negedge clk);
        check_code(64, "R1 reset preset");

        cur_req = "R7"; pulse(1, 30); pulse(1, 30);
        check_code(64, "R7 disabled wire ignored");

        enable_wait();
        cur_req = "R5"; pulse(1, 30);
        check_code(64, "R5 first pulse discarded");

        cur_req = "R2"; pulse(1, 30);
        check_code(65, "R2 low pulse increments");
        pulse(1, TA);
        check_code(66, "R2 exact threshold width");

        cur_req = "R3"; pulse(-1, 30);
        check_code(65, "R3 high pulse decrements");

        cur_req = "R11";
        @(negedge clk); ctl_hi_i = 1;
        repeat (30) @(negedge clk);
        ctl_hi_i = 0;
        @(negedge clk); @(negedge clk);
        check_code(65, "R11 no step before third edge");
        @(negedge clk);
        check_code(64, "R11 step at third edge");
        idle(10);

        cur_req = "R4"; pulse(1, 3); pulse(-1, 2);
        check_code(64, "R4 glitches rejected");
        pulse(1, 12); pulse(-1, TA - 1);
        check_code(64, "R4 mid-band widths rejected");

        cur_req = "R6";
        @(negedge clk); ctl_lo_i = 1; repeat (30) @(negedge clk);
        ctl_lo_i = 0; repeat (2) @(negedge clk);
        ctl_lo_i = 1; repeat (30) @(negedge clk);
        ctl_lo_i = 0; repeat (10) @(negedge clk);
        check_code(65, "R6 short gap refuses second pulse");

        cur_req = "R9";
        @(negedge clk); ctl_lo_i = 1; repeat (30) @(negedge clk);
        ctl_lo_i = 0; ctl_hi_i = 1; repeat (30) @(negedge clk);
        ctl_hi_i = 0; repeat (10) @(negedge clk);
        check_code(65, "R9 reversal gives no step");

        cur_req = "R10"; pulse(2, 30);
        check_code(65, "R10 both flags act as mid");
        pulse(-1, 30);
        check_code(64, "R10 pulse after both-flag rest counts");

        cur_req = "R7";
        @(negedge clk); en_i = 0; repeat (5) @(negedge clk);
        pulse(1, 30);
        check_code(64, "R7 ignored while disabled");
        @(negedge clk); en_i = 1; repeat (4) @(negedge clk);
        pulse(1, 25);
        check_code(64, "R7 pulse during start-up ignored");
        repeat (TS) @(negedge clk);
        cur_req = "R5"; pulse(1, 30);
        check_code(64, "R5 first pulse after re-enable discarded");
        pulse(1, 30);
        check_code(65, "R5 second pulse after re-enable counts");

        cur_req = "R8"; do_reset(126);
        check_code(126, "R1 reload 126");
        enable_wait();
        pulse(1, 30); pulse(1, 30); pulse(1, 30); pulse(1, 30);
        check_code(127, "R8 saturate at 127");
        do_reset(1);
        enable_wait();
        pulse(-1, 30); pulse(-1, 30); pulse(-1, 30); pulse(-1, 30);
        check_code(0, "R8 saturate at 0");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule